// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block behaves as a 1-kbit serial EEPROM on a three-wire select/clock/data bus. A host raises the select line, clocks in a start bit, a two-bit opcode, an address and, for write-type commands, a data word. The block then reads from, programs or erases a register array held in flops. A strap input fixes the organisation at 64 words of 16 bits or 128 bytes of 8 bits.

The serial pins are sampled by the block's own system clock. Serial clock and select edges are found after a two-stage synchroniser. The serial data output comes with a separate enable, so the pad can be tri-stated outside read and status phases. Programming commands are accepted only while a write-enable latch is set, and they start when select falls. Programming then runs for a fixed number of system-clock cycles. During that time the data output reports busy or ready while select is high.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the data output enable is low, the write-enable latch is clear and every stored bit reads as 1.
- R2: No operation takes place until a serial clock rise sees select and data-in both high. Rises with data-in low, or with select low, are ignored.
- R3: After the start bit the host sends the opcode and then the address, MSB first, on serial clock rises. The opcodes are 10 READ, 01 WRITE, 11 ERASE and 00 extended. For an extended command the two address MSBs select 11 enable-programming, 00 disable-programming, 01 erase-all or 10 write-all.
- R4: While the write-enable latch is clear, WRITE, ERASE, erase-all and write-all change nothing and start no programming cycle. Enable-programming sets the latch and disable-programming clears it. READ works with the latch in either state.
- R5: On the rise that loads the last address bit, a READ turns the output on with a 0 dummy bit. Each following rise presents the next data bit, MSB first.
- R6: While select stays high after the last bit of a word, the address increments, wrapping at the top of the array. The next word follows with no dummy bit.
- R7: Org high selects 16-bit words with 6 address bits. Org low selects bytes with 7 address bits. Byte address 2n is the upper half of word n, and byte address 2n+1 is the lower half.
- R8: WRITE stores the data word and ERASE sets every bit of the addressed word to 1. Either takes effect only when select falls after the last required bit. If select falls earlier, the command is dropped.
- R9: Erase-all sets the whole array to 1s. Write-all copies its data word into every word, or into every byte when org is low.
- R10: When select goes high during a programming cycle, the output is enabled and drives 0 while busy and 1 once ready. The output is disabled again after select falls.
- R11: A programming cycle lasts PROG_CYCLES system clocks. Start bits and commands clocked in while it runs are ignored.
- R12: Once a non-read command has received all its bits, further serial clocks and data are ignored until select falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | Organisation strap: 1 = 16-bit words, 0 = bytes |
| do_o | output | 1 | Serial data out |
| do_oe_o | output | 1 | Output enable for do_o |

## Verification
The hardest condition to reach is a complete, well-formed command arriving while a programming cycle is still running. It must have no effect at all. The stimulus starts a word write, raises select again to observe busy, and then clocks a full write to a second address inside the busy window. A later read shows that the second address is unchanged. Early select release, trailing clocks and organisation changes between commands are interleaved with seeded random traffic.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_DONE,
        ST_STATUS
    } st_e;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        PEND_NONE,
        PEND_ONE,
        PEND_ALL
    } pend_e;

    localparam logic [1:0] EXT_PROG_ON  = 2'b11;
    localparam logic [1:0] EXT_PROG_OFF = 2'b00;
    localparam logic [1:0] EXT_FILL_1   = 2'b01;
    localparam logic [1:0] EXT_FILL_D   = 2'b10;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = async_i;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign sync_o = s2_q;
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int unsigned PROG_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int unsigned CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CW'(PROG_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    assert_start_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
endmodule

// File: rtl/mw_array.sv
module mw_array #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              all_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [1:0]        wmask_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [WORD_W-1:0] rdata_o
);
    localparam int unsigned N_WORDS = 1 << ADDR_W;
    localparam int unsigned BYTE_W  = WORD_W / 2;

    logic [WORD_W-1:0] words [N_WORDS];

    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        logic [WORD_W-1:0] w_d, w_q;
        logic              hit;

        assign hit = we_i && (all_i || (waddr_i == ADDR_W'(g)));

        always_comb begin
            w_d = w_q;
            if (hit) begin
                if (wmask_i[1]) w_d[WORD_W-1:BYTE_W] = wdata_i[WORD_W-1:BYTE_W];
                if (wmask_i[0]) w_d[BYTE_W-1:0]      = wdata_i[BYTE_W-1:0];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) w_q <= '1;
            else        w_q <= w_d;
        end

        assign words[g] = w_q;
    end

    assign rdata_o = words[raddr_i];

    assert_fill_full_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && all_i) |-> (wmask_i == 2'b11));
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
    import mw_eeprom_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              sck_i,
    input  logic              di_i,
    input  logic              org_i,
    input  logic              busy_i,
    input  logic [WORD_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] raddr_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic              we_o,
    output logic              all_o,
    output logic              prog_start_o,
    output logic [1:0]        wmask_o,
    output logic [WORD_W-1:0] wdata_o,
    output logic              do_o,
    output logic              oe_o
);
    localparam int unsigned BYTE_W = WORD_W / 2;
    localparam int unsigned AW8    = ADDR_W + 1;
    localparam int unsigned CNT_W  = $clog2(AW8 + WORD_W + 3);
    localparam int unsigned IDX_W  = $clog2(WORD_W);

    typedef struct packed {
        st_e               st;
        logic              sck_prev;
        logic              cs_prev;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        op;
        logic [AW8-1:0]    addr;
        logic [WORD_W-1:0] data;
        logic              wen;
        logic              dummy;
        logic [IDX_W-1:0]  idx;
        pend_e             pend;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic              sck_rise, cs_fall;
    logic [CNT_W-1:0]  nbits, aw_c, dw_c;
    logic [IDX_W-1:0]  dw_m1;
    logic [AW8-1:0]    amask, a_shift, a_inc;
    logic [1:0]        ext;
    logic [BYTE_W-1:0] byte_sel;
    logic              rd_bit;

    assign sck_rise = sck_i && !s_q.sck_prev;
    assign cs_fall  = !cs_i && s_q.cs_prev;
    assign aw_c     = org_i ? CNT_W'(ADDR_W) : CNT_W'(AW8);
    assign dw_c     = org_i ? CNT_W'(WORD_W) : CNT_W'(BYTE_W);
    assign dw_m1    = org_i ? IDX_W'(WORD_W - 1) : IDX_W'(BYTE_W - 1);
    assign amask    = org_i ? {1'b0, {ADDR_W{1'b1}}} : {AW8{1'b1}};
    assign nbits    = s_q.cnt + 1'b1;
    assign a_shift  = {s_q.addr[AW8-2:0], di_i} & amask;
    assign a_inc    = (s_q.addr + 1'b1) & amask;
    assign ext      = org_i ? a_shift[ADDR_W-1 -: 2] : a_shift[AW8-1 -: 2];

    always_comb begin
        s_d          = s_q;
        s_d.sck_prev = sck_i;
        s_d.cs_prev  = cs_i;
        we_o         = 1'b0;
        prog_start_o = 1'b0;

        if (cs_fall) begin
            if (s_q.pend != PEND_NONE && s_q.wen) begin
                we_o         = 1'b1;
                prog_start_o = 1'b1;
            end
            s_d.st   = ST_IDLE;
            s_d.pend = PEND_NONE;
        end else begin
            case (s_q.st)
                ST_IDLE, ST_STATUS: begin
                    if (s_q.st == ST_IDLE && cs_i && busy_i) begin
                        s_d.st = ST_STATUS;
                    end else if (sck_rise && cs_i && di_i && !busy_i) begin
                        s_d.st   = ST_CMD;
                        s_d.cnt  = '0;
                        s_d.op   = '0;
                        s_d.addr = '0;
                        s_d.data = '0;
                        s_d.pend = PEND_NONE;
                    end
                end
                ST_CMD: begin
                    if (sck_rise) begin
                        s_d.cnt = nbits;
                        if (nbits <= CNT_W'(2)) begin
                            s_d.op = {s_q.op[0], di_i};
                        end else if (nbits <= CNT_W'(2) + aw_c) begin
                            s_d.addr = a_shift;
                            if (nbits == CNT_W'(2) + aw_c) begin
                                case (op_e'(s_q.op))
                                    OP_READ: begin
                                        s_d.st    = ST_READ;
                                        s_d.dummy = 1'b1;
                                        s_d.idx   = dw_m1;
                                    end
                                    OP_ERASE: begin
                                        s_d.pend = PEND_ONE;
                                        s_d.data = '1;
                                        s_d.st   = ST_DONE;
                                    end
                                    OP_EXT: begin
                                        case (ext)
                                            EXT_PROG_ON: begin
                                                s_d.wen = 1'b1;
                                                s_d.st  = ST_DONE;
                                            end
                                            EXT_PROG_OFF: begin
                                                s_d.wen = 1'b0;
                                                s_d.st  = ST_DONE;
                                            end
                                            EXT_FILL_1: begin
                                                s_d.pend = PEND_ALL;
                                                s_d.data = '1;
                                                s_d.st   = ST_DONE;
                                            end
                                            default: ;
                                        endcase
                                    end
                                    default: ;
                                endcase
                            end
                        end else begin
                            s_d.data = {s_q.data[WORD_W-2:0], di_i};
                            if (nbits == CNT_W'(2) + aw_c + dw_c) begin
                                s_d.pend = (s_q.op == OP_WRITE) ? PEND_ONE : PEND_ALL;
                                s_d.st   = ST_DONE;
                            end
                        end
                    end
                end
                ST_READ: begin
                    if (sck_rise) begin
                        if (s_q.dummy) begin
                            s_d.dummy = 1'b0;
                        end else if (s_q.idx == '0) begin
                            s_d.addr = a_inc;
                            s_d.idx  = dw_m1;
                        end else begin
                            s_d.idx = s_q.idx - 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.pend <= PEND_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign raddr_o  = org_i ? s_q.addr[ADDR_W-1:0] : s_q.addr[AW8-1:1];
    assign waddr_o  = raddr_o;
    assign all_o    = (s_q.pend == PEND_ALL);
    assign wmask_o  = (org_i || all_o) ? 2'b11 : (s_q.addr[0] ? 2'b01 : 2'b10);
    assign wdata_o  = org_i ? s_q.data : {s_q.data[BYTE_W-1:0], s_q.data[BYTE_W-1:0]};
    assign byte_sel = s_q.addr[0] ? rdata_i[BYTE_W-1:0] : rdata_i[WORD_W-1:BYTE_W];
    assign rd_bit   = org_i ? rdata_i[s_q.idx] : byte_sel[s_q.idx[IDX_W-2:0]];

    always_comb begin
        do_o = 1'b0;
        oe_o = 1'b0;
        if (s_q.st == ST_READ) begin
            oe_o = 1'b1;
            do_o = s_q.dummy ? 1'b0 : rd_bit;
        end else if (s_q.st == ST_STATUS) begin
            oe_o = 1'b1;
            do_o = !busy_i;
        end
    end

    assert_latch_set_by_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.wen) |-> ($past(s_q.st) == ST_CMD));

    assert_dummy_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_READ && $past(s_q.st) != ST_READ) |-> (oe_o && !do_o));

    assert_hiz_after_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_i) |=> !oe_o);

    assert_busy_holds_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_STATUS && busy_i && cs_i) |=> (s_q.st == ST_STATUS || s_q.st == ST_IDLE));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned PROG_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sck_i,
    input  logic di_i,
    input  logic org_i,
    output logic do_o,
    output logic do_oe_o
);
    logic [3:0]        pins_s;
    logic              busy, we, all, pstart;
    logic [ADDR_W-1:0] raddr, waddr;
    logic [1:0]        wmask;
    logic [WORD_W-1:0] wdata, rdata;

    mw_sync #(.W(4)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_i, sck_i, di_i, org_i}),
        .sync_o  (pins_s)
    );

    mw_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_i         (pins_s[3]),
        .sck_i        (pins_s[2]),
        .di_i         (pins_s[1]),
        .org_i        (pins_s[0]),
        .busy_i       (busy),
        .rdata_i      (rdata),
        .raddr_o      (raddr),
        .waddr_o      (waddr),
        .we_o         (we),
        .all_o        (all),
        .prog_start_o (pstart),
        .wmask_o      (wmask),
        .wdata_o      (wdata),
        .do_o         (do_o),
        .oe_o         (do_oe_o)
    );

    mw_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .all_i   (all),
        .waddr_i (waddr),
        .wmask_i (wmask),
        .wdata_i (wdata),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );

    mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (pstart),
        .busy_o  (busy)
    );

    assert_write_starts_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> busy);
endmodule

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb;
    localparam int PROG = 400;
    localparam int HP   = 4;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sck = 1'b0, di = 1'b0, org = 1'b1;
    logic do_w, oe_w;
    int   n_chk = 0, n_fail = 0;
    logic [7:0] mem8 [128];
    bit   wen_m = 0;

    always #5 clk = ~clk;

    mw_eeprom #(.PROG_CYCLES(PROG)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .di_i(di), .org_i(org),
        .do_o(do_w), .do_oe_o(oe_w)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bitx(input logic b, output logic o, output logic e);
        di = b;
        wclk(1);
        sck = 1'b1;
        wclk(HP);
        sck = 1'b0;
        wclk(HP);
        o = do_w;
        e = oe_w;
    endtask

    task automatic cs_on();
        cs = 1'b1;
        wclk(HP);
    endtask

    task automatic cs_off();
        cs = 1'b0;
        di = 1'b0;
        wclk(6);
    endtask

    task automatic set_org(input bit x16);
        org = x16;
        wclk(4);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [6:0] a, input bit x16,
                            output logic o, output logic e);
        bitx(1'b1, o, e);
        bitx(op[1], o, e);
        bitx(op[0], o, e);
        for (int i = (x16 ? 5 : 6); i >= 0; i--) bitx(a[i], o, e);
    endtask

    function automatic logic [15:0] exp_word(input bit x16, input logic [6:0] a);
        if (x16) return {mem8[{a[5:0], 1'b0}], mem8[{a[5:0], 1'b1}]};
        return {8'h00, mem8[a]};
    endfunction

    function automatic void model_put(input bit x16, input logic [6:0] a, input logic [15:0] d);
        if (x16) begin
            mem8[{a[5:0], 1'b0}] = d[15:8];
            mem8[{a[5:0], 1'b1}] = d[7:0];
        end else begin
            mem8[a] = d[7:0];
        end
    endfunction

    task automatic read_chk(input string req, input bit x16, input logic [6:0] a0, input int nw);
        logic o, e;
        logic [15:0] got;
        logic [6:0]  a;
        a = a0;
        cs_on();
        send_hdr(2'b10, a, x16, o, e);
        chk(req, "dummy bit {oe,do}", {30'd0, e, o}, 32'd2);
        for (int w = 0; w < nw; w++) begin
            got = '0;
            for (int k = 0; k < (x16 ? 16 : 8); k++) begin
                bitx(1'b0, o, e);
                got = {got[14:0], o};
            end
            chk(req, $sformatf("read addr %0d", a), {16'd0, got}, {16'd0, exp_word(x16, a)});
            a = x16 ? ((a + 7'd1) & 7'h3f) : (a + 7'd1);
        end
        cs_off();
    endtask

    task automatic poll(input string req, input bit expect_prog, input bit cmd_in_busy);
        logic o, e;
        int k;
        cs = 1'b0;
        wclk(4);
        cs = 1'b1;
        wclk(8);
        if (expect_prog) begin
            chk(req, "busy status {oe,do}", {30'd0, oe_w, do_w}, 32'd2);
            if (cmd_in_busy) begin
                // R11: complete write to address 13 clocked in while busy
                send_hdr(2'b01, 7'd13, 1'b1, o, e);
                for (int i = 15; i >= 0; i--) bitx(1'b1 ^ i[0], o, e);
                chk("R11", "still busy after ignored command", {30'd0, oe_w, do_w}, 32'd2);
            end
            k = 0;
            while (!do_w && k < PROG + 60) begin
                wclk(1);
                k++;
            end
            chk("R10", "ready status {oe,do}", {30'd0, oe_w, do_w}, 32'd3);
            if (!cmd_in_busy)
                chk("R11", "busy span", {31'd0, (k >= PROG - 40 && k <= PROG + 20)}, 32'd1);
        end else begin
            chk(req, "no programming started (oe)", {31'd0, oe_w}, 32'd0);
        end
        cs_off();
        chk("R10", "output off after select falls", {31'd0, oe_w}, 32'd0);
    endtask

    task automatic do_write(input string req, input bit x16, input logic [6:0] a, input logic [15:0] d,
                            input int lead, input int tail, input bit cmd_in_busy);
        logic o, e;
        cs_on();
        for (int i = 0; i < lead; i++) bitx(1'b0, o, e);
        send_hdr(2'b01, a, x16, o, e);
        for (int i = (x16 ? 15 : 7); i >= 0; i--) bitx(d[i], o, e);
        for (int i = 0; i < tail; i++) bitx(1'b1, o, e);
        if (wen_m) model_put(x16, a, d);
        poll(req, wen_m, cmd_in_busy);
    endtask

    task automatic do_erase(input string req, input bit x16, input logic [6:0] a);
        logic o, e;
        cs_on();
        send_hdr(2'b11, a, x16, o, e);
        if (wen_m) model_put(x16, a, 16'hffff);
        poll(req, wen_m, 1'b0);
    endtask

    task automatic do_ext(input string req, input bit x16, input logic [1:0] code, input logic [15:0] d);
        logic o, e;
        logic [6:0] a;
        a = x16 ? {1'b0, code, 4'b0101} : {code, 5'b10110};
        cs_on();
        send_hdr(2'b00, a, x16, o, e);
        if (code == 2'b10) for (int i = (x16 ? 15 : 7); i >= 0; i--) bitx(d[i], o, e);
        case (code)
            2'b11: begin wen_m = 1; cs_off(); end
            2'b00: begin wen_m = 0; cs_off(); end
            default: begin
                if (wen_m)
                    for (int i = 0; i < 128; i++)
                        mem8[i] = (code == 2'b01) ? 8'hff : (x16 ? (i[0] ? d[7:0] : d[15:8]) : d[7:0]);
                poll(req, wen_m, 1'b0);
            end
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic o, e;
        void'($urandom(32'd7211));
        for (int i = 0; i < 128; i++) mem8[i] = 8'hff;
        wclk(5);
        rst_n = 1'b1;
        wclk(4);

        // R1: reset state
        chk("R1", "output enable after reset", {31'd0, oe_w}, 32'd0);
        read_chk("R1", 1'b1, 7'd5, 1);

        // R2: clocks with select low and data high do nothing
        for (int i = 0; i < 3; i++) bitx(1'b1, o, e);
        chk("R2", "no op with select low", {31'd0, oe_w}, 32'd0);

        // R4: write blocked before enabling
        do_write("R4", 1'b1, 7'd3, 16'h1234, 0, 0, 1'b0);
        read_chk("R4", 1'b1, 7'd3, 1);

        // R3: enable-programming, then R2 leading zeros before start
        do_ext("R3", 1'b1, 2'b11, 16'h0);
        do_write("R2", 1'b1, 7'd3, 16'ha5c3, 3, 0, 1'b0);
        read_chk("R5", 1'b1, 7'd3, 1);

        // R7: byte view of word 3, byte write seen through word view
        set_org(1'b0);
        read_chk("R7", 1'b0, 7'd6, 2);
        do_write("R7", 1'b0, 7'd9, 16'h003c, 0, 0, 1'b0);
        set_org(1'b1);
        read_chk("R7", 1'b1, 7'd4, 1);

        // R6: sequential read across the top of the array
        do_write("R6", 1'b1, 7'd63, 16'h8e71, 0, 0, 1'b0);
        read_chk("R6", 1'b1, 7'd62, 4);

        // R8: erase, and early select release drops a write
        do_erase("R8", 1'b1, 7'd3);
        read_chk("R8", 1'b1, 7'd3, 1);
        cs_on();
        send_hdr(2'b01, 7'd10, 1'b1, o, e);
        for (int i = 0; i < 5; i++) bitx(1'b0, o, e);
        poll("R8", 1'b0, 1'b0);
        read_chk("R8", 1'b1, 7'd10, 1);

        // R12: trailing clocks after a complete write
        do_write("R12", 1'b1, 7'd11, 16'h0f0f, 0, 5, 1'b0);
        read_chk("R12", 1'b1, 7'd11, 1);

        // R11: full command while busy is ignored
        do_write("R11", 1'b1, 7'd12, 16'h5aa5, 0, 0, 1'b1);
        read_chk("R11", 1'b1, 7'd12, 2);

        // R9: fill with data, then fill with ones
        do_ext("R9", 1'b1, 2'b10, 16'h1234);
        read_chk("R9", 1'b1, 7'd0, 2);
        read_chk("R9", 1'b1, 7'd63, 1);
        set_org(1'b0);
        do_ext("R9", 1'b0, 2'b10, 16'h00c6);
        read_chk("R9", 1'b0, 7'd77, 2);
        do_ext("R9", 1'b0, 2'b01, 16'h0);
        read_chk("R9", 1'b0, 7'd127, 2);
        set_org(1'b1);

        // R4: disable then write ignored
        do_ext("R4", 1'b1, 2'b00, 16'h0);
        do_write("R4", 1'b1, 7'd20, 16'hbeef, 0, 0, 1'b0);
        read_chk("R4", 1'b1, 7'd20, 1);

        // Random traffic
        for (int it = 0; it < 30; it++) begin
            bit x16;
            logic [6:0] a;
            logic [15:0] d;
            int sel;
            sel = int'($urandom % 6);
            x16 = bit'($urandom % 2);
            a   = 7'($urandom);
            if (x16) a[6] = 1'b0;
            d   = 16'($urandom);
            if (!x16) d[15:8] = 8'h00;
            set_org(x16);
            case (sel)
                0, 1: begin
                    do_write("R8", x16, a, d, 0, 0, 1'b0);
                    read_chk("R5", x16, a, 1);
                end
                2: begin
                    do_erase("R8", x16, a);
                    read_chk("R8", x16, a, 1);
                end
                3: read_chk("R6", x16, a, 2);
                4: do_ext("R4", x16, 2'b11, 16'h0);
                default: do_ext("R4", x16, 2'b00, 16'h0);
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule